// File: doc/BRIEF.md
# Keystream Random Word Generator

This block produces random words from the keystream of a nonlinear shift-register stream cipher. The cipher state is 288 bits wide and is split into three chained shift registers. Every round takes taps from the three registers, combines them with XOR, and feeds one AND term back into each register. The block unrolls a parameterised number of rounds in each clock. That number is also the width of the output word, so one advance of the state yields one full word.

The generator is seeded with an 80-bit key and an 80-bit initialisation value. Default values are parameters and are loaded by the synchronous reset. A one-clock load strobe loads new values at run time. After every load the state runs 1152 warm-up rounds, and the keystream bits from those rounds are thrown away. Words go to the consumer through a valid/ready handshake: a word stays on the output until the consumer takes it. The output is random data for test and simulation use. It is not meant to protect anything.

Top module: `ks_keystream_gen`

## Requirements
- R1: When `rst_i` is high at a clock edge, the state is loaded from the `DEF_KEY` and `DEF_IV` parameters, and `vld_o` and `word_o` go to zero after that edge.
- R2: When `seed_load_i` is high at a clock edge and `rst_i` is low, the state is loaded from `key_i` and `iv_i`, and `vld_o` is low after that edge. When both are high, the reset wins and the default values are loaded.
- R3: State layout on a load, with the state bits numbered s1..s288: key bit k goes to s(k+1) for k = 0..79, IV bit k goes to s(94+k), and s286, s287 and s288 are set to one. All other bits are zero.
- R4: Each round forms t1 = s66^s93, t2 = s162^s177 and t3 = s243^s288, and emits z = t1^t2^t3. It then sets t1 ^= (s91&s92)^s171, t2 ^= (s175&s176)^s264 and t3 ^= (s286&s287)^s69. The first register s1..s93 shifts up with t3 entering s1, the second register s94..s177 with t1 entering s94, and the third register s178..s288 with t2 entering s178.
- R5: After a load, the 1152 warm-up rounds run on the next 1152/W clocks whether or not `rdy_i` is high, and their output is discarded. The first valid word appears after the (1152/W + 1)-th rising edge following the load edge, so `vld_o` is low for exactly 1152/W + 1 sampled cycles, counting the load cycle.
- R6: Each advance runs W rounds. The z bit of the j-th round of that clock (j = 0 first) is placed at `word_o[j]`.
- R7: The state advances only on clocks where `rdy_i` is high or `vld_o` is low. When `vld_o` is high and `rdy_i` is low, `word_o` and `vld_o` keep their values.
- R8: Once `vld_o` is high, it stays high until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high; loads the default seed |
| seed_load_i | input | 1 | Load `key_i`/`iv_i` into the state on this clock |
| key_i | input | 80 | Run-time key |
| iv_i | input | 80 | Run-time initialisation value |
| rdy_i | input | 1 | Consumer takes the current word |
| vld_o | output | 1 | `word_o` holds a valid word |
| word_o | output | W | Random word, first-generated bit in bit 0 |

## Verification
The bench builds the block with W = 32. This gives a 36-clock warm-up, so many reseeds and long streams fit in a short run, and every word covers 32 chained rounds of the feedback logic. A separate reference model keeps the three registers in their own arrays with their own indexing and replays the load, the warm-up count and the handshake. Stalls come from a randomly driven ready signal. Directed cases cover reseeding while a word is stalled, reset and reseed asserted together, and counting the warm-up length with ready held low.

// File: rtl/ks_pkg.sv
package ks_pkg;
  localparam int unsigned STATE_BITS = 288;
  localparam int unsigned SEED_BITS  = 80;
  localparam int unsigned WARM_ROUNDS = 1152;

  typedef logic [STATE_BITS-1:0] ks_state_t;

  typedef struct packed {
    ks_state_t s;
    logic      z;
  } ks_step_t;

  // Bit i of the vector holds state bit s(i+1).
  function automatic ks_state_t ks_load(input logic [SEED_BITS-1:0] key,
                                        input logic [SEED_BITS-1:0] iv);
    ks_state_t r;
    r          = '0;
    r[79:0]    = key;
    r[172:93]  = iv;
    r[287:285] = 3'b111;
    return r;
  endfunction

  function automatic ks_step_t ks_round(input ks_state_t s);
    ks_step_t r;
    logic ta, tb, tc;
    ta  = s[65]  ^ s[92];
    tb  = s[161] ^ s[176];
    tc  = s[242] ^ s[287];
    r.z = ta ^ tb ^ tc;
    ta  = ta ^ (s[90]  & s[91])  ^ s[170];
    tb  = tb ^ (s[174] & s[175]) ^ s[263];
    tc  = tc ^ (s[285] & s[286]) ^ s[68];
    r.s = {s[286:177], tb, s[175:93], ta, s[91:0], tc};
    return r;
  endfunction
endpackage

// File: rtl/ks_round_chain.sv
module ks_round_chain
  import ks_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  ks_state_t     cur_i,
  output ks_state_t     nxt_o,
  output logic [W-1:0]  bits_o
);
  ks_state_t chain [0:W];

  assign chain[0] = cur_i;

  for (genvar j = 0; j < W; j++) begin : g_round
    ks_step_t st;
    assign st         = ks_round(chain[j]);
    assign chain[j+1] = st.s;
    assign bits_o[j]  = st.z;
  end

  assign nxt_o = chain[W];
endmodule

// File: rtl/ks_warmup.sv
module ks_warmup
  import ks_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic load_i,
  input  logic adv_i,
  input  logic vld_i,
  output logic done_o
);
  localparam int unsigned WARM_CYC = WARM_ROUNDS / W;
  localparam int unsigned CW       = $clog2(WARM_CYC + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(WARM_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (load_i)
      cnt_q <= CNT_INIT;
    else if (adv_i && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  AST_WARM_NO_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
    !done_o |-> !vld_i); // R5
  AST_WARM_RELOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> cnt_q == CNT_INIT); // R5
endmodule

// File: rtl/ks_out_stage.sv
module ks_out_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         seed_load_i,
  input  logic         rdy_i,
  input  logic         warm_done_i,
  input  logic [W-1:0] bits_i,
  output logic         adv_o,
  output logic         vld_o,
  output logic [W-1:0] word_o
);
  assign adv_o = rdy_i || !vld_o;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      vld_o  <= 1'b0;
      word_o <= '0;
    end else if (seed_load_i) begin
      vld_o  <= 1'b0;
    end else if (adv_o && warm_done_i) begin
      vld_o  <= 1'b1;
      word_o <= bits_i;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (vld_o && !rdy_i && !seed_load_i) |=> (vld_o && $stable(word_o))); // R7
  AST_VALID_STAYS: assert property (@(posedge clk_i) disable iff (rst_i)
    (vld_o && !seed_load_i) |=> vld_o); // R8
  AST_LOAD_DROPS: assert property (@(posedge clk_i) disable iff (rst_i)
    seed_load_i |=> !vld_o); // R2
endmodule

// File: rtl/ks_keystream_gen.sv
module ks_keystream_gen
  import ks_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter logic [79:0] DEF_KEY = 80'h31415926535897932384,
  parameter logic [79:0] DEF_IV  = 80'h0123456789abcdefa50f
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         seed_load_i,
  input  logic [79:0]  key_i,
  input  logic [79:0]  iv_i,
  input  logic         rdy_i,
  output logic         vld_o,
  output logic [W-1:0] word_o
);
  ks_state_t    state_q;
  ks_state_t    state_nxt;
  logic [W-1:0] ks_bits;
  logic         adv;
  logic         warm_done;
  logic         any_load;

  assign any_load = rst_i || seed_load_i;

  ks_round_chain #(.W(W)) u_chain (
    .cur_i  (state_q),
    .nxt_o  (state_nxt),
    .bits_o (ks_bits)
  );

  // Priority: reset, then run-time load, then stepping.
  always_ff @(posedge clk_i) begin
    if (rst_i)
      state_q <= ks_load(DEF_KEY, DEF_IV);
    else if (seed_load_i)
      state_q <= ks_load(key_i, iv_i);
    else if (adv)
      state_q <= state_nxt;
  end

  ks_warmup #(.W(W)) u_warm (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (any_load),
    .adv_i  (adv),
    .vld_i  (vld_o),
    .done_o (warm_done)
  );

  ks_out_stage #(.W(W)) u_out (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .seed_load_i (seed_load_i),
    .rdy_i       (rdy_i),
    .warm_done_i (warm_done),
    .bits_i      (ks_bits),
    .adv_o       (adv),
    .vld_o       (vld_o),
    .word_o      (word_o)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk_i)
    rst_i |=> (!vld_o && word_o == '0)); // R1
endmodule

// File: tb/tb_ks_keystream_gen.sv
module tb_ks_keystream_gen;
  localparam int W = 32;
  localparam int WARM = 1152 / W;
  localparam logic [79:0] DK = 80'h31415926535897932384;
  localparam logic [79:0] DI = 80'h0123456789abcdefa50f;

  logic clk = 1'b0;
  logic rst = 1'b1, sl = 1'b0, rdy = 1'b0;
  logic [79:0] key = '0, iv = '0;
  logic vld;
  logic [W-1:0] word;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ks_keystream_gen #(.W(W), .DEF_KEY(DK), .DEF_IV(DI)) dut (
    .clk_i(clk), .rst_i(rst), .seed_load_i(sl), .key_i(key), .iv_i(iv),
    .rdy_i(rdy), .vld_o(vld), .word_o(word)
  );

  // Reference model: three registers held separately, indexed from one.
  logic [1:93]  ra;
  logic [1:84]  rb;
  logic [1:111] rc;
  int mcnt;
  bit mvld;
  logic [W-1:0] mword;

  task automatic m_load(input logic [79:0] k, input logic [79:0] v);
    ra = '0; rb = '0; rc = '0;
    for (int i = 1; i <= 80; i++) begin
      ra[i] = k[i-1];
      rb[i] = v[i-1];
    end
    rc[109] = 1'b1; rc[110] = 1'b1; rc[111] = 1'b1;
  endtask

  task automatic m_round(output logic z);
    logic p, q, r;
    p = ra[66] ^ ra[93];
    q = rb[69] ^ rb[84];
    r = rc[66] ^ rc[111];
    z = p ^ q ^ r;
    p = p ^ (ra[91] & ra[92]) ^ rb[78];
    q = q ^ (rb[82] & rb[83]) ^ rc[87];
    r = r ^ (rc[109] & rc[110]) ^ ra[69];
    for (int i = 93; i > 1; i--) ra[i] = ra[i-1];
    for (int i = 84; i > 1; i--) rb[i] = rb[i-1];
    for (int i = 111; i > 1; i--) rc[i] = rc[i-1];
    ra[1] = r; rb[1] = p; rc[1] = q;
  endtask

  always @(posedge clk) begin
    logic [W-1:0] acc;
    logic zb;
    if (rst) begin
      m_load(DK, DI); mcnt = WARM; mvld = 0; mword = '0;
    end else if (sl) begin
      m_load(key, iv); mcnt = WARM; mvld = 0;
    end else if (!mvld || rdy) begin
      for (int j = 0; j < W; j++) begin
        m_round(zb);
        acc[j] = zb;
      end
      if (mcnt > 0) mcnt = mcnt - 1;
      else begin mword = acc; mvld = 1; end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive inputs for one cycle, then compare at the falling edge.
  task automatic cyc(input bit r, input bit s, input bit rd,
                     input logic [79:0] k, input logic [79:0] v);
    bit held;
    logic [W-1:0] w0;
    rst = r; sl = s; rdy = rd; key = k; iv = v;
    held = vld && !rd && !r && !s;
    w0 = word;
    @(negedge clk);
    check(vld == mvld, "R5 R8 vld", W'(vld), W'(mvld));
    if (mvld) check(word == mword, "R3 R4 R6 word", word, mword);
    if (held) check(vld && word == w0, "R7 stall hold", word, w0);
  endtask

  initial begin
    int lows;
    logic [79:0] rk, rv;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    cyc(1, 0, 0, '0, '0);
    check(vld == 1'b0, "R1 reset vld", W'(vld), '0);
    check(word == '0, "R1 reset word", word, '0);

    // Default seed stream with random back-pressure.
    for (int i = 0; i < 300; i++) cyc(0, 0, ($urandom % 10) < 7, '0, '0);

    // Directed seed, warm-up length counted with ready held low.
    lows = 0;
    cyc(0, 1, 0, 80'h0053A6F94C9FF24598EB, 80'h0D74DB42A91077DE45AC);
    if (!vld) lows++;
    for (int i = 0; i < WARM + 4; i++) begin
      cyc(0, 0, 0, '0, '0);
      if (!vld) lows++;
    end
    check(lows == WARM + 1, "R5 warm-up length", W'(lows), W'(WARM + 1));
    for (int i = 0; i < 200; i++) cyc(0, 0, 1, '0, '0);

    // Reseed while a word is stalled.
    cyc(0, 0, 0, '0, '0);
    cyc(0, 1, 0, 80'hA5A5_0F0F_1234_5678_9ABC, 80'h1111_2222_3333_4444_5555);
    check(vld == 1'b0, "R2 reseed drops valid", W'(vld), '0);
    for (int i = 0; i < 120; i++) cyc(0, 0, ($urandom % 2), '0, '0);

    // Reset and reseed together: defaults must win.
    cyc(1, 1, 1, 80'hFFFF_FFFF_FFFF_FFFF_FFFF, 80'hFFFF_FFFF_FFFF_FFFF_FFFF);
    check(vld == 1'b0 && word == '0, "R2 reset priority", word, '0);
    for (int i = 0; i < 80; i++) cyc(0, 0, 1, '0, '0);

    // Random seeds with random back-pressure.
    for (int n = 0; n < 20; n++) begin
      rk = {$urandom, $urandom, 16'($urandom)};
      rv = {$urandom, $urandom, 16'($urandom)};
      cyc(0, 1, $urandom % 2, rk, rv);
      for (int i = 0; i < 90; i++) cyc(0, 0, ($urandom % 4) != 0, '0, '0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R5 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule